// File: doc/BRIEF.md
# Relocatable Shared Memory Window Decoder

This block sits between a host address bus and a shared RAM. It decides whether each host access falls inside a movable window and, if it does, turns the host address into a local RAM address. Software moves the window by writing a base register. It picks the window size, from 8 KB to 64 KB, with a two-bit code that it can read back. A page register can map a larger RAM through a fixed 8 KB window, one page at a time.

The installed RAM may be smaller than the window. A host write that lands inside the window but past the end of the RAM is blocked, and the block flags it on a one-cycle violation output. A read of such a location returns zero. The window stays closed after reset until software has written the base register.

The hit flag, the RAM address, the RAM write strobe and the read data are combinational from the host inputs. The violation output is registered and appears in the cycle after the offending write.

Top module: `smw_window_dec`

## Requirements
- R1: After reset, all three configuration registers read back as 0. No hit is reported until the base register (select 0) has been written.
- R2: Writing select 0 places data bits 7:1 into the window base, which is compared against host address bits 19:13. Data bit 0 is ignored, and the register reads back with bit 0 clear.
- R3: Register select 1 holds the size code in data bits 3:2: 00 = 8 KB, 01 = 16 KB, 10 = 32 KB, 11 = 64 KB. All other bits of this register read as 0.
- R4: With paging off, a hit requires host address bits 19:13 to equal the base only in the bit positions at or above the size code. For size code c, base bits below c are ignored.
- R5: With paging off, the RAM address of a hit is the host address masked to its low 13+c bits.
- R6: Writing select 2 turns paging on only when data bits 7:6 are both 1; any other value turns it off. Data bits 2:0, ANDed with the page mask, become the page number. The register reads back as {en,en,000,page}.
- R7: With paging on, the window is 8 KB: all seven base bits must match. The RAM address is {page, host address bits 12:0}.
- R8: A hit write whose RAM address is at or above RAM_BYTES does not assert ram_we_o, and viol_o is 1 in the following cycle. An in-range hit write asserts ram_we_o and leaves viol_o at 0.
- R9: A hit read whose RAM address is at or above RAM_BYTES returns 0. An in-range hit read returns ram_rdata_i. A miss returns 0.
- R10: No hit is reported while host_valid_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration register write strobe |
| cfg_sel_i | input | 2 | Register select: 0 base, 1 size, 2 page |
| cfg_wdata_i | input | 8 | Configuration write data |
| cfg_rdata_o | output | 8 | Read-back of the selected register |
| host_valid_i | input | 1 | Host access valid |
| host_we_i | input | 1 | Host access is a write |
| host_addr_i | input | 20 | Host byte address |
| host_wdata_i | input | 8 | Host write data |
| host_rdata_o | output | 8 | Host read data |
| hit_o | output | 1 | Access falls inside the window |
| ram_addr_o | output | 16 | Local RAM address |
| ram_we_o | output | 1 | RAM write strobe |
| ram_wdata_o | output | 8 | RAM write data |
| ram_rdata_i | input | 8 | RAM read data |
| viol_o | output | 1 | Access violation pulse |

## Verification
Four properties are checked on every cycle:
- no hit is ever reported while the window is closed or the host is idle;
- the RAM write strobe never goes out with an address past the installed RAM;
- nonzero read data only appears on a hit;
- each violation follows a hit write.

The size-code read-back is also checked in the cycle after every size write. Only the bench scenarios can show the address arithmetic itself. That covers the masked base compare at each size code, the exact local address with paging on and off, the page mask, the paging-enable pattern, and the zero data returned past the end of the RAM.

// File: rtl/smw_pkg.sv
package smw_pkg;
  localparam int HOST_AW  = 20;
  localparam int BASE_LSB = 13;
  localparam int BASE_W   = HOST_AW - BASE_LSB;
  localparam int SIZE_W   = 2;
  localparam int LOC_AW   = BASE_LSB + (1 << SIZE_W) - 1;
  localparam int PG_W     = LOC_AW - BASE_LSB;
  localparam int DW       = 8;

  typedef enum logic [1:0] {
    SEL_BASE = 2'd0,
    SEL_SIZE = 2'd1,
    SEL_PAGE = 2'd2,
    SEL_RSVD = 2'd3
  } cfg_sel_e;

  typedef struct packed {
    logic              win_en;
    logic [BASE_W-1:0] base;
    logic [SIZE_W-1:0] size_code;
    logic              pg_en;
    logic [PG_W-1:0]   page;
  } win_cfg_t;
endpackage

// File: rtl/smw_cfg_regs.sv
module smw_cfg_regs
  import smw_pkg::*;
#(
  parameter logic [PG_W-1:0] PAGE_MASK = '1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [1:0]    sel_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output win_cfg_t      cfg_o
);
  win_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (we_i) begin
      case (cfg_sel_e'(sel_i))
        SEL_BASE: begin
          cfg_q.base   <= wdata_i[DW-1:1];
          cfg_q.win_en <= 1'b1;
        end
        SEL_SIZE: cfg_q.size_code <= wdata_i[3:2];
        SEL_PAGE: begin
          cfg_q.pg_en <= &wdata_i[7:6];
          cfg_q.page  <= wdata_i[PG_W-1:0] & PAGE_MASK;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    case (cfg_sel_e'(sel_i))
      SEL_BASE: rdata_o = {cfg_q.base, 1'b0};
      SEL_SIZE: rdata_o[3:2] = cfg_q.size_code;
      SEL_PAGE: begin
        rdata_o[7:6]      = {2{cfg_q.pg_en}};
        rdata_o[PG_W-1:0] = cfg_q.page;
      end
      default: rdata_o = '0;
    endcase
  end

  assign cfg_o = cfg_q;

  // R3
  size_readback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(we_i) && $past(sel_i) == SEL_SIZE && sel_i == SEL_SIZE)
      |-> rdata_o[3:2] == $past(wdata_i[3:2]));
endmodule

// File: rtl/smw_match.sv
module smw_match
  import smw_pkg::*;
(
  input  logic               valid_i,
  input  logic [HOST_AW-1:0] addr_i,
  input  win_cfg_t           cfg_i,
  output logic               hit_o,
  output logic [LOC_AW-1:0]  loc_o
);
  logic [BASE_W-1:0] cmp_mask;
  logic [LOC_AW-1:0] off_mask;
  logic [BASE_W-1:0] diff;

  always_comb begin
    cmp_mask = cfg_i.pg_en ? '1 : ({BASE_W{1'b1}} << cfg_i.size_code);
    diff     = addr_i[HOST_AW-1:BASE_LSB] ^ cfg_i.base;
    hit_o    = valid_i && cfg_i.win_en && ((diff & cmp_mask) == '0);
  end

  always_comb begin
    off_mask = ~({LOC_AW{1'b1}} << (BASE_LSB + int'(cfg_i.size_code)));
    if (cfg_i.pg_en) loc_o = {cfg_i.page, addr_i[BASE_LSB-1:0]};
    else             loc_o = addr_i[LOC_AW-1:0] & off_mask;
  end
endmodule

// File: rtl/smw_guard.sv
module smw_guard
  import smw_pkg::*;
#(
  parameter int RAM_BYTES = 24576
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hit_i,
  input  logic              we_i,
  input  logic [LOC_AW-1:0] loc_i,
  input  logic [DW-1:0]     ram_rdata_i,
  output logic              ram_we_o,
  output logic [DW-1:0]     rdata_o,
  output logic              viol_o
);
  localparam logic [LOC_AW:0] LIMIT = (LOC_AW+1)'(RAM_BYTES);

  logic oob;
  logic viol_q;

  assign oob      = {1'b0, loc_i} >= LIMIT;
  assign ram_we_o = hit_i && we_i && !oob;
  assign rdata_o  = (hit_i && !oob) ? ram_rdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) viol_q <= 1'b0;
    else         viol_q <= hit_i && we_i && oob;
  end

  assign viol_o = viol_q;

  // R8
  viol_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |-> $past(hit_i && we_i));
endmodule

// File: rtl/smw_window_dec.sv
module smw_window_dec
  import smw_pkg::*;
#(
  parameter int               RAM_BYTES = 24576,
  parameter logic [PG_W-1:0]  PAGE_MASK = '1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [1:0]         cfg_sel_i,
  input  logic [DW-1:0]      cfg_wdata_i,
  output logic [DW-1:0]      cfg_rdata_o,
  input  logic               host_valid_i,
  input  logic               host_we_i,
  input  logic [HOST_AW-1:0] host_addr_i,
  input  logic [DW-1:0]      host_wdata_i,
  output logic [DW-1:0]      host_rdata_o,
  output logic               hit_o,
  output logic [LOC_AW-1:0]  ram_addr_o,
  output logic               ram_we_o,
  output logic [DW-1:0]      ram_wdata_o,
  input  logic [DW-1:0]      ram_rdata_i,
  output logic               viol_o
);
  win_cfg_t cfg;

  smw_cfg_regs #(.PAGE_MASK(PAGE_MASK)) i_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .sel_i   (cfg_sel_i),
    .wdata_i (cfg_wdata_i),
    .rdata_o (cfg_rdata_o),
    .cfg_o   (cfg)
  );

  smw_match i_match (
    .valid_i (host_valid_i),
    .addr_i  (host_addr_i),
    .cfg_i   (cfg),
    .hit_o   (hit_o),
    .loc_o   (ram_addr_o)
  );

  smw_guard #(.RAM_BYTES(RAM_BYTES)) i_guard (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hit_i       (hit_o),
    .we_i        (host_we_i),
    .loc_i       (ram_addr_o),
    .ram_rdata_i (ram_rdata_i),
    .ram_we_o    (ram_we_o),
    .rdata_o     (host_rdata_o),
    .viol_o      (viol_o)
  );

  assign ram_wdata_o = host_wdata_i;

  // R1
  closed_no_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg.win_en |-> !hit_o);
  // R10
  idle_no_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> host_valid_i);
  // R8
  we_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> (hit_o && host_we_i && (32'(ram_addr_o) < RAM_BYTES)));
  // R9
  rdata_on_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_rdata_o != '0) |-> hit_o);
endmodule

// File: tb/test_smw_window_dec.sv
`timescale 1ns/1ps
module test_smw_window_dec;
  localparam int RAM_BYTES = 24576;
  localparam logic [2:0] PAGE_MASK = 3'b111;

  typedef struct {
    logic        hit;
    logic [15:0] loc;
    logic [7:0]  rdata;
    logic        we;
    logic        viol;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [7:0]  cfg_wdata = 8'd0;
  logic [7:0]  cfg_rdata;
  logic        h_valid = 1'b0;
  logic        h_we = 1'b0;
  logic [19:0] h_addr = 20'd0;
  logic [7:0]  h_wdata = 8'd0;
  logic [7:0]  h_rdata;
  logic        hit;
  logic [15:0] ram_addr;
  logic        ram_we;
  logic [7:0]  ram_wdata;
  logic [7:0]  ram_rdata;
  logic        viol;

  int checks = 0;
  int errors = 0;
  item_t q[$];
  logic done = 1'b0;

  logic       m_en = 1'b0;
  logic [6:0] m_base = 7'd0;
  logic [1:0] m_code = 2'd0;
  logic       m_pg = 1'b0;
  logic [2:0] m_page = 3'd0;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] mem_f(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  assign ram_rdata = mem_f(ram_addr);

  smw_window_dec #(.RAM_BYTES(RAM_BYTES), .PAGE_MASK(PAGE_MASK)) i_smw_window_dec (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .host_valid_i(h_valid), .host_we_i(h_we), .host_addr_i(h_addr), .host_wdata_i(h_wdata),
    .host_rdata_o(h_rdata), .hit_o(hit), .ram_addr_o(ram_addr), .ram_we_o(ram_we),
    .ram_wdata_o(ram_wdata), .ram_rdata_i(ram_rdata), .viol_o(viol)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    h_valid = 1'b0;
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    case (sel)
      2'd0: begin m_base = d[7:1]; m_en = 1'b1; end
      2'd1: m_code = d[3:2];
      2'd2: begin m_pg = &d[7:6]; m_page = d[2:0] & PAGE_MASK; end
      default: ;
    endcase
  endtask

  task automatic cfg_read(input logic [1:0] sel, input logic [7:0] exp, input string tag);
    @(negedge clk);
    cfg_sel = sel;
    #1 check(tag, {24'd0, cfg_rdata}, {24'd0, exp});
  endtask

  // driver: drives one host access and queues the expected result
  task automatic acc(input logic [19:0] a, input logic w, input logic v, input string tag);
    item_t it;
    logic [6:0]  mask;
    logic [15:0] loc;
    logic        oob;
    mask = m_pg ? 7'h7F : (7'h7F << m_code);
    it.hit = v && m_en && (((a[19:13] ^ m_base) & mask) == 7'd0);
    loc = m_pg ? {m_page, a[12:0]} : (a[15:0] & ~(16'hFFFF << (13 + int'(m_code))));
    oob = 32'(loc) >= RAM_BYTES;
    it.loc   = loc;
    it.rdata = (it.hit && !oob) ? mem_f(loc) : 8'd0;
    it.we    = it.hit && w && !oob;
    it.viol  = it.hit && w && oob;
    it.tag   = tag;
    @(negedge clk);
    h_valid = v; h_we = w; h_addr = a; h_wdata = a[7:0];
    q.push_back(it);
  endtask

  // monitor: compares one cycle's results after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        check({it.tag, " hit"}, {31'd0, hit}, {31'd0, it.hit});
        if (it.hit) check({it.tag, " addr"}, {16'd0, ram_addr}, {16'd0, it.loc});
        check({it.tag, " rdata"}, {24'd0, h_rdata}, {24'd0, it.rdata});
        check({it.tag, " we"}, {31'd0, ram_we}, {31'd0, it.we});
        check({it.tag, " viol"}, {31'd0, viol}, {31'd0, it.viol});
      end else if (rst_n) begin
        check("R8 idle viol", {31'd0, viol}, 32'd0);
      end
    end
  end

  initial begin
    fork
      begin
        repeat (4) @(posedge clk);
        rst_n = 1'b1;
        cfg_read(2'd0, 8'h00, "R1 base reset");
        cfg_read(2'd1, 8'h00, "R1 size reset");
        cfg_read(2'd2, 8'h00, "R1 page reset");
        acc(20'h00000, 1'b0, 1'b1, "R1 closed window");
        acc(20'h00010, 1'b1, 1'b1, "R1 closed write");
        cfg_write(2'd0, 8'h1B);
        cfg_read(2'd0, 8'h1A, "R2 base readback");
        acc(20'h1A010, 1'b0, 1'b1, "R2 R5 8K hit");
        acc(20'h1C010, 1'b0, 1'b1, "R4 8K miss");
        acc(20'h1A010, 1'b0, 1'b0, "R10 idle");
        cfg_write(2'd1, 8'hFF);
        cfg_read(2'd1, 8'h0C, "R3 size readback ff");
        cfg_write(2'd1, 8'h04);
        cfg_read(2'd1, 8'h04, "R3 size 16K");
        acc(20'h18100, 1'b0, 1'b1, "R4 16K low half");
        acc(20'h1A100, 1'b0, 1'b1, "R5 16K high half");
        acc(20'h1C000, 1'b0, 1'b1, "R4 16K miss");
        cfg_write(2'd1, 8'h08);
        acc(20'h1DFFF, 1'b1, 1'b1, "R8 last byte write");
        acc(20'h1E000, 1'b1, 1'b1, "R8 oob write");
        acc(20'h1E001, 1'b1, 1'b1, "R8 oob write again");
        acc(20'h1E000, 1'b0, 1'b1, "R9 oob read");
        acc(20'h18000, 1'b0, 1'b1, "R9 in range read");
        cfg_write(2'd1, 8'h0C);
        acc(20'h10000, 1'b0, 1'b1, "R4 64K bottom");
        acc(20'h0FFFF, 1'b0, 1'b1, "R4 64K below");
        cfg_write(2'd2, 8'hC2);
        cfg_read(2'd2, 8'hC2, "R6 page on readback");
        acc(20'h1A123, 1'b0, 1'b1, "R7 paged read");
        acc(20'h18000, 1'b0, 1'b1, "R7 paged 8K miss");
        acc(20'h1A456, 1'b1, 1'b1, "R7 paged write");
        cfg_write(2'd2, 8'hC5);
        acc(20'h1A000, 1'b1, 1'b1, "R8 paged oob write");
        cfg_write(2'd2, 8'h85);
        cfg_read(2'd2, 8'h05, "R6 page off readback");
        acc(20'h18000, 1'b0, 1'b1, "R6 paging off 64K hit");
        acc(20'h1FFFF, 1'b1, 1'b1, "R8 64K top oob write");
        @(negedge clk);
        h_valid = 1'b0;
        repeat (3) @(posedge clk);
        #2;
      end
      begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule